// File: doc/BRIEF.md
# CAN Controller Global Control Register

This block holds the 8-bit global control byte of a CAN controller. It also contains the sequencing logic that turns those bits into control signals for the protocol engine. The CPU writes the byte through a simple write port and can read the current value back at any time.

From the stored bits the block derives the following signals for the engine:

- a run/standby state, which includes a start-up delay and a drain phase that lets a frame in progress finish before the controller freezes;
- a one-cycle soft-reset pulse;
- a strobe that clears the enable bit of every mailbox while an abort is requested;
- an overload-frame request, which hardware withdraws when the overload frame starts;
- a clock enable;
- a forced-recessive transmit override and a receiver enable.

In time-triggered mode the block copies an external free-running timer into a stamp register. The copy is taken either at start-of-frame or at the last bit of end-of-frame, depending on a select bit.

Top module: `can_glob_ctrl`

## Requirements
- R1: After reset the register reads 0x00, `ctrl_active` and `clk_en` are 0, `tx_force_rec` is 1 and `stamp` is 0.
- R2: The bit positions of the byte are: bit 7 abort, bit 6 overload request, bit 5 time-triggered mode, bit 4 capture select, bit 3 autobaud, bit 2 test, bit 1 enable, bit 0 soft reset. A write stores bits 7..1, and a read returns the stored value with bit 0 always reading 0. `autobaud`, `test_mode` and `tt_mode` follow bits 3, 2 and 5.
- R3: A write with bit 0 set clears the whole register at that clock edge and drives `soft_rst` high for exactly the following cycle. The sequencer is then forced back to standby.
- R4: `clk_en` rises one edge after the edge that stores enable = 1. `ctrl_active` rises two edges after that edge.
- R5: When enable is cleared while `frame_busy` is 1, `ctrl_active` stays 1 until the first edge at which `frame_busy` is sampled 0. If `frame_busy` is already 0, `ctrl_active` drops at the next edge.
- R6: While `ctrl_active` is 0, `tx_force_rec` is 1 and `rx_en` is 0. Once the controller is back in standby, `clk_en` is 0.
- R7: While the abort bit is set and `ctrl_active` is 1, `mbox_en_clr` is all ones; otherwise it is all zeros. The abort bit stays set until software clears it.
- R8: `ovl_req` equals the overload bit while `ctrl_active` is 1. An `ovl_start` event clears the bit at that edge, and this takes priority over a CPU write in the same cycle.
- R9: With time-triggered mode set and `ctrl_active` high, `stamp` loads `timer` on `sof` when the select bit is 0, or on `eof_last` when it is 1. The other event, and any event while the mode is off, leaves `stamp` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 8 | CPU write byte |
| rd_data | output | 8 | Current register value |
| frame_busy | input | 1 | Engine has a frame in progress |
| sof | input | 1 | Start-of-frame event |
| eof_last | input | 1 | Last bit of end-of-frame event |
| ovl_start | input | 1 | Overload frame transmission begins |
| timer | input | TW | Free-running timer value |
| ctrl_active | output | 1 | Controller state machine running |
| clk_en | output | 1 | Controller clock enable |
| tx_force_rec | output | 1 | Force transmit line recessive |
| rx_en | output | 1 | Receiver enable |
| soft_rst | output | 1 | One-cycle soft reset pulse |
| mbox_en_clr | output | MBOX_N | Per-mailbox enable clear strobe |
| ovl_req | output | 1 | Overload frame request to engine |
| tt_mode | output | 1 | Time-triggered mode |
| autobaud | output | 1 | Autobaud mode |
| test_mode | output | 1 | Test mode |
| stamp | output | TW | Captured timer value |

## Verification
The assertions run on every cycle and check four things:

- the overload clear wins over a write in the same cycle;
- the soft-reset write empties the register and emits the pulse;
- `ctrl_active` never rises without enable having been held for the start delay, and it holds while a frame drains;
- the stamp stays frozen whenever capture is not armed, and loads on the selected event.

Other behaviours appear only in the bench's scenarios: the exact edge at which `clk_en` and `ctrl_active` change, the abort strobe covering all mailboxes, the unselected capture event being ignored, and standby returning to forced-recessive. The bench's behavioural reference model checks these on every clock.

// File: rtl/can_gc_pkg.sv
package can_gc_pkg;

    typedef struct packed {
        logic abort_rq;
        logic ovl_rq;
        logic tt_on;
        logic tt_eof_sel;
        logic baud_auto;
        logic test_md;
        logic run_en;
        logic sw_reset;
    } gc_reg_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WAKE  = 2'd1,
        PH_RUN   = 2'd2,
        PH_DRAIN = 2'd3
    } run_phase_t;

    function automatic logic phase_active(run_phase_t p);
        return (p == PH_RUN) || (p == PH_DRAIN);
    endfunction

endpackage

// File: rtl/gc_regfile.sv
module gc_regfile
    import can_gc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       ovl_clr,
    output gc_reg_t    q,
    output logic       srst_pulse
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q          <= '0;
            srst_pulse <= 1'b0;
        end else begin
            srst_pulse <= 1'b0;
            if (wr_en && wr_data[0]) begin
                q          <= '0;
                srst_pulse <= 1'b1;
            end else begin
                if (wr_en) begin
                    q <= gc_reg_t'({wr_data[7:1], 1'b0});
                end
                if (ovl_clr) begin
                    q.ovl_rq <= 1'b0;
                end
            end
        end
    end

    AST_OVL_HW_WINS: assert property (@(posedge clk) disable iff (rst)
        ovl_clr |=> !q.ovl_rq); // R8

    AST_GRES_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[0]) |=> (q == '0) && srst_pulse); // R3

    AST_SRST_SINGLE: assert property (@(posedge clk) disable iff (rst)
        srst_pulse |=> !srst_pulse || $past(wr_en && wr_data[0])); // R3

endmodule

// File: rtl/gc_run_seq.sv
module gc_run_seq
    import can_gc_pkg::*;
#(
    parameter int START_DLY = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       frame_busy,
    output run_phase_t phase
);

    localparam int CW = $clog2(START_DLY + 1);

    logic [CW-1:0] wake_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            wake_cnt <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    wake_cnt <= '0;
                    if (en) phase <= PH_WAKE;
                end
                PH_WAKE: begin
                    if (!en) begin
                        phase <= PH_IDLE;
                    end else if (wake_cnt == CW'(START_DLY - 2)) begin
                        phase <= PH_RUN;
                    end else begin
                        wake_cnt <= wake_cnt + 1'b1;
                    end
                end
                PH_RUN: begin
                    if (!en) phase <= frame_busy ? PH_DRAIN : PH_IDLE;
                end
                default: begin
                    if (en)               phase <= PH_RUN;
                    else if (!frame_busy) phase <= PH_IDLE;
                end
            endcase
        end
    end

    AST_START_DELAY: assert property (@(posedge clk) disable iff (rst)
        $rose(phase_active(phase)) |-> $past(en) && $past(en, 2)); // R4

    AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (phase_active(phase) && !en && frame_busy) |=> phase_active(phase)); // R5

endmodule

// File: rtl/gc_stamp.sv
module gc_stamp #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm,
    input  logic          eof_sel,
    input  logic          sof,
    input  logic          eof_last,
    input  logic [TW-1:0] timer,
    output logic [TW-1:0] stamp
);

    logic hit;

    always_comb hit = arm && (eof_sel ? eof_last : sof);

    always_ff @(posedge clk) begin
        if (rst)      stamp <= '0;
        else if (hit) stamp <= timer;
    end

    AST_STAMP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !arm |=> $stable(stamp)); // R9

    AST_STAMP_SOF: assert property (@(posedge clk) disable iff (rst)
        (arm && !eof_sel && sof) |=> stamp == $past(timer)); // R9

endmodule

// File: rtl/can_glob_ctrl.sv
module can_glob_ctrl
    import can_gc_pkg::*;
#(
    parameter int MBOX_N    = 8,
    parameter int TW        = 16,
    parameter int START_DLY = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    input  logic              frame_busy,
    input  logic              sof,
    input  logic              eof_last,
    input  logic              ovl_start,
    input  logic [TW-1:0]     timer,
    output logic              ctrl_active,
    output logic              clk_en,
    output logic              tx_force_rec,
    output logic              rx_en,
    output logic              soft_rst,
    output logic [MBOX_N-1:0] mbox_en_clr,
    output logic              ovl_req,
    output logic              tt_mode,
    output logic              autobaud,
    output logic              test_mode,
    output logic [TW-1:0]     stamp
);

    gc_reg_t    cfg;
    run_phase_t phase;
    logic       srst_q;
    logic       core_rst;

    gc_regfile u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .ovl_clr    (ovl_start),
        .q          (cfg),
        .srst_pulse (srst_q)
    );

    always_comb core_rst = rst || srst_q;

    gc_run_seq #(.START_DLY(START_DLY)) u_seq (
        .clk        (clk),
        .rst        (core_rst),
        .en         (cfg.run_en),
        .frame_busy (frame_busy),
        .phase      (phase)
    );

    gc_stamp #(.TW(TW)) u_stamp (
        .clk      (clk),
        .rst      (core_rst),
        .arm      (cfg.tt_on && ctrl_active),
        .eof_sel  (cfg.tt_eof_sel),
        .sof      (sof),
        .eof_last (eof_last),
        .timer    (timer),
        .stamp    (stamp)
    );

    always_comb begin
        rd_data      = cfg;
        ctrl_active  = phase_active(phase);
        clk_en       = (phase != PH_IDLE);
        tx_force_rec = !ctrl_active;
        rx_en        = ctrl_active;
        soft_rst     = srst_q;
        mbox_en_clr  = (cfg.abort_rq && ctrl_active) ? '1 : '0;
        ovl_req      = cfg.ovl_rq && ctrl_active;
        tt_mode      = cfg.tt_on;
        autobaud     = cfg.baud_auto;
        test_mode    = cfg.test_md;
    end

    AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (cfg.abort_rq && !wr_en && !ovl_start) |=> cfg.abort_rq); // R7

    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!clk_en) |=> !ctrl_active); // R6

endmodule

// File: tb/can_glob_ctrl_bench.sv
module can_glob_ctrl_bench;

    localparam int MB = 8;
    localparam int TW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic frame_busy = 1'b0, sof = 1'b0, eof_last = 1'b0, ovl_start = 1'b0;
    logic [TW-1:0] timer = '0;

    logic [7:0]    rd_data;
    logic          ctrl_active, clk_en, tx_force_rec, rx_en, soft_rst;
    logic [MB-1:0] mbox_en_clr;
    logic          ovl_req, tt_mode, autobaud, test_mode;
    logic [TW-1:0] stamp;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    always @(negedge clk) timer <= timer + 16'd3;

    can_glob_ctrl #(.MBOX_N(MB), .TW(TW), .START_DLY(2)) u_can_glob_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .frame_busy(frame_busy), .sof(sof), .eof_last(eof_last), .ovl_start(ovl_start),
        .timer(timer), .ctrl_active(ctrl_active), .clk_en(clk_en),
        .tx_force_rec(tx_force_rec), .rx_en(rx_en), .soft_rst(soft_rst),
        .mbox_en_clr(mbox_en_clr), .ovl_req(ovl_req), .tt_mode(tt_mode),
        .autobaud(autobaud), .test_mode(test_mode), .stamp(stamp)
    );

    // behavioural reference: phase 0 standby, 1 waking, 2 running, 3 draining
    logic [7:0]    m_reg = '0;
    bit            m_srst = 0;
    int            m_ph = 0;
    int            m_wait = 0;
    logic [TW-1:0] m_stamp = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_reg = '0; m_srst = 0; m_ph = 0; m_wait = 0; m_stamp = '0;
        end else begin
            bit act;
            bit en;
            act = (m_ph >= 2);
            en  = m_reg[1];
            if (m_srst) m_stamp = '0;
            else if (act && m_reg[5] && (m_reg[4] ? eof_last : sof)) m_stamp = timer;
            if (m_srst) begin
                m_ph = 0;
            end else if (m_ph == 0) begin
                if (en) begin m_ph = 1; m_wait = 1; end
            end else if (m_ph == 1) begin
                if (!en) m_ph = 0;
                else if (m_wait >= 1) m_ph = 2;
            end else if (m_ph == 2) begin
                if (!en) m_ph = frame_busy ? 3 : 0;
            end else begin
                if (en) m_ph = 2;
                else if (!frame_busy) m_ph = 0;
            end
            m_srst = 0;
            if (wr_en && wr_data[0]) begin
                m_reg = '0; m_srst = 1;
            end else begin
                if (wr_en) m_reg = wr_data & 8'hFE;
                if (ovl_start) m_reg[6] = 1'b0;
            end
        end
    end

    task automatic cmp(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            bit a;
            a = (m_ph >= 2);
            cmp("R2 rd_data", rd_data, m_reg);
            cmp("R2 autobaud/test/tt", {autobaud, test_mode, tt_mode}, {m_reg[3], m_reg[2], m_reg[5]});
            cmp("R3 soft_rst", soft_rst, m_srst);
            cmp("R4 ctrl_active", ctrl_active, a);
            cmp("R6 clk_en", clk_en, m_ph != 0);
            cmp("R6 tx_force_rec/rx_en", {tx_force_rec, rx_en}, {!a, a});
            cmp("R7 mbox_en_clr", mbox_en_clr, (m_reg[7] && a) ? 8'hFF : 8'h00);
            cmp("R8 ovl_req", ovl_req, m_reg[6] && a);
            cmp("R9 stamp", stamp, m_stamp);
        end
    end

    task automatic wr(logic [7:0] b);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_data = b;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // which: 0 sof, 1 eof_last, 2 ovl_start
    task automatic ev(int which);
        @(negedge clk); #1;
        if (which == 0) sof = 1'b1;
        else if (which == 1) eof_last = 1'b1;
        else ovl_start = 1'b1;
        @(negedge clk); #1;
        sof = 1'b0; eof_last = 1'b0; ovl_start = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [TW-1:0] snap;
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #1;
        cmp("R1 reset rd", rd_data, 8'h00);
        cmp("R1 reset active/clk_en/tx", {ctrl_active, clk_en, tx_force_rec}, 3'b001);
        cmp("R1 reset stamp", stamp, 0);

        wr(8'h0D);
        cmp("R2 bit0 reads zero after gres write", rd_data, 8'h00);
        idle(2);
        wr(8'h0C);
        cmp("R2 readback", rd_data, 8'h0C);
        cmp("R2 passthrough", {autobaud, test_mode}, 2'b11);

        wr(8'h02);
        cmp("R4 edge0", {clk_en, ctrl_active}, 2'b00);
        idle(1);
        cmp("R4 edge1", {clk_en, ctrl_active}, 2'b10);
        idle(1);
        cmp("R4 edge2", {clk_en, ctrl_active}, 2'b11);

        wr(8'h82);
        cmp("R7 abort strobe", mbox_en_clr, 8'hFF);
        idle(5);
        cmp("R7 abort sticky", rd_data[7], 1);
        wr(8'h02);
        cmp("R7 abort released", mbox_en_clr, 8'h00);

        wr(8'h42);
        cmp("R8 ovl_req set", ovl_req, 1);
        ev(2);
        cmp("R8 hw clear", rd_data[6], 0);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_data = 8'h42; ovl_start = 1'b1;
        @(negedge clk); #1;
        wr_en = 1'b0; ovl_start = 1'b0;
        cmp("R8 clear beats write", rd_data[6], 0);

        wr(8'h22);
        ev(1);
        cmp("R9 eof ignored when sof selected", stamp, 0);
        @(negedge clk); #1; sof = 1'b1; snap = timer;
        @(negedge clk); #1; sof = 1'b0;
        cmp("R9 sof capture", stamp, snap);
        wr(8'h32);
        ev(0);
        cmp("R9 sof ignored when eof selected", stamp, snap);
        @(negedge clk); #1; eof_last = 1'b1; snap = timer;
        @(negedge clk); #1; eof_last = 1'b0;
        cmp("R9 eof capture", stamp, snap);
        wr(8'h12);
        ev(0); ev(1);
        cmp("R9 mode off no capture", stamp, snap);

        frame_busy = 1'b1;
        wr(8'h00);
        idle(4);
        cmp("R5 drain holds active", ctrl_active, 1);
        frame_busy = 1'b0;
        idle(1);
        cmp("R5 drops after frame", ctrl_active, 0);
        cmp("R6 standby outputs", {tx_force_rec, rx_en, clk_en}, 3'b100);

        wr(8'h02);
        idle(3);
        wr(8'h00);
        idle(1);
        cmp("R5 idle disable drops at once", ctrl_active, 0);

        wr(8'h02);
        idle(3);
        wr(8'h0B);
        cmp("R3 register cleared", rd_data, 8'h00);
        cmp("R3 pulse", soft_rst, 1);
        idle(1);
        cmp("R3 pulse single", soft_rst, 0);
        cmp("R3 disabled after reset", {ctrl_active, clk_en}, 2'b00);
        idle(3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule